// File: doc/BRIEF.md
# Integer Adder with Carry, Overflow and Condition Flags

This block adds two 64-bit operands, plus an optional immediate, in a single combinational path. Operand A can be bitwise inverted before the addition. Beside the sum, the block keeps a small set of status flags in registers: a carry flag for the full width, a carry flag for the low half, a signed-overflow flag and a sticky summary-overflow flag. When recording is requested, it also presents a 4-bit condition field that classifies the signed result.

Each flag group is written only when its enable is set and the valid strobe is high. The groups are handled in a fixed order: carry first, then overflow, then the condition field. As a result, the condition field already carries the summary-overflow value produced by the same operation. A separate clear input zeroes the summary-overflow flag. When a clear and an overflow arrive in the same cycle, the clear wins.

Top module: `addx_flags`

## Requirements
- R1: `sum` is, combinationally and modulo 2^64, the sum of A' (`op_a`, or `~op_a` when `inv_a` is 1), `op_b`, and `imm` when `imm_en` is 1.
- R2: On a clock edge with `valid` and `carry_en` both 1, `ca` becomes 1 exactly when the unsigned `sum` is smaller than A', smaller than `op_b`, or (when `imm_en` is 1) smaller than `imm`; otherwise `ca` becomes 0.
- R3: `ca32` follows the R2 rule, applied to bits 31:0 of each operand and of the sum.
- R4: On a clock edge with `valid` and `ov_en` both 1, `ov` becomes 1 exactly when bit 63 of A' equals bit 63 of `op_b` and bit 63 of `sum` differs from it; otherwise `ov` becomes 0.
- R5: `ca` and `ca32` keep their values unless `valid` and `carry_en` are both 1. `ov` keeps its value unless `valid` and `ov_en` are both 1.
- R6: `so` is sticky. On a clock edge with `valid` and `ov_en` both 1 (and `clr_so` at 0), `so` becomes `so | new ov`. No add ever clears it.
- R7: A clock edge with `clr_so` at 1 sets `so` to 0, and this overrides the sticky OR in the same cycle.
- R8: `cr_vld` equals `valid & rec_en`. `cr_field` is {negative, positive, zero, so'}, with bit 3 the negative flag, computed from `sum` read as a signed value. so' is the value `so` takes at the next edge.
- R9: A synchronous reset (`rst` at 1) clears `ca`, `ca32`, `ov` and `so`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | The operation on the inputs is taken this cycle |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| imm | input | 64 | Immediate addend |
| imm_en | input | 1 | Includes `imm` in the sum |
| inv_a | input | 1 | Complements `op_a` before the addition |
| carry_en | input | 1 | Updates `ca` and `ca32` |
| ov_en | input | 1 | Updates `ov` and `so` |
| rec_en | input | 1 | Requests the condition field |
| clr_so | input | 1 | Clears the summary-overflow flag |
| sum | output | 64 | Result |
| ca | output | 1 | Full-width carry flag |
| ca32 | output | 1 | Low-half carry flag |
| ov | output | 1 | Signed-overflow flag |
| so | output | 1 | Sticky summary-overflow flag |
| cr_field | output | 4 | {negative, positive, zero, summary overflow} |
| cr_vld | output | 1 | `cr_field` is meaningful |

## Verification
A carry out of bit 31 with no carry out of bit 63 separates `ca32` from `ca`. Adding one to the largest positive value, and adding two copies of the most negative value, reach overflow from both sign directions. The second case also wraps to zero, which tests the zero bit of the condition field and the full carry. An operation with no overflow, run after an overflow, shows that `so` is sticky, and a clear issued during an overflowing operation shows that the clear has priority. Operations with the enables low, with the immediate in use, and with A inverted check that the flags are held and that the right addends are selected.

// File: rtl/addx_flags.sv
module addx_flags #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] imm,
  input  logic         imm_en,
  input  logic         inv_a,
  input  logic         carry_en,
  input  logic         ov_en,
  input  logic         rec_en,
  input  logic         clr_so,
  output logic [W-1:0] sum,
  output logic         ca,
  output logic         ca32,
  output logic         ov,
  output logic         so,
  output logic [3:0]   cr_field,
  output logic         cr_vld
);
  localparam int H = W / 2;

  logic [W-1:0] a_eff, imm_eff;
  logic         ca_n, ca32_n, ov_n, so_upd, do_carry, do_ov;

  assign a_eff   = inv_a  ? ~op_a : op_a;
  assign imm_eff = imm_en ? imm   : '0;
  assign sum     = a_eff + op_b + imm_eff;

  assign ca_n   = (sum < a_eff) || (sum < op_b) || (imm_en && (sum < imm));
  assign ca32_n = (sum[H-1:0] < a_eff[H-1:0]) || (sum[H-1:0] < op_b[H-1:0]) ||
                  (imm_en && (sum[H-1:0] < imm[H-1:0]));
  assign ov_n   = (a_eff[W-1] == op_b[W-1]) && (sum[W-1] != a_eff[W-1]);

  assign do_carry = valid && carry_en;
  assign do_ov    = valid && ov_en;
  assign so_upd   = clr_so ? 1'b0 : (do_ov ? (so | ov_n) : so);

  assign cr_field = {sum[W-1], !sum[W-1] && (|sum), ~|sum, so_upd};
  assign cr_vld   = valid && rec_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ca   <= 1'b0;
      ca32 <= 1'b0;
      ov   <= 1'b0;
      so   <= 1'b0;
    end else begin
      if (do_carry) begin
        ca   <= ca_n;
        ca32 <= ca32_n;
      end
      if (do_ov) ov <= ov_n;
      so <= so_upd;
    end
  end
endmodule

// File: rtl/addx_flags_chk.sv
module addx_flags_chk (
  input logic       clk,
  input logic       rst,
  input logic       valid,
  input logic       carry_en,
  input logic       ov_en,
  input logic       clr_so,
  input logic       ca,
  input logic       ca32,
  input logic       ov,
  input logic       so,
  input logic [3:0] cr_field
);
  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(valid && carry_en) |=> $stable(ca) && $stable(ca32)); // R5
  AST_OV_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(valid && ov_en) |=> $stable(ov)); // R5
  AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (so && !clr_so) |=> so); // R6
  AST_SO_FOLD: assert property (@(posedge clk) disable iff (rst)
    (valid && ov_en && !clr_so) |=> (so == ($past(so) | ov))); // R6
  AST_SO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_so |=> !so); // R7
  AST_RESET_FLAGS: assert property (@(posedge clk)
    rst |=> !ca && !ca32 && !ov && !so); // R9
  AST_CR_CLASS: assert property (@(posedge clk) disable iff (rst)
    $countones(cr_field[3:1]) == 1); // R8
endmodule

bind addx_flags addx_flags_chk u_chk (
  .clk(clk), .rst(rst), .valid(valid), .carry_en(carry_en), .ov_en(ov_en),
  .clr_so(clr_so), .ca(ca), .ca32(ca32), .ov(ov), .so(so), .cr_field(cr_field)
);

// File: tb/addx_flags_tb.sv
module addx_flags_tb;
  logic        clk = 1'b0;
  logic        rst, valid, imm_en, inv_a, carry_en, ov_en, rec_en, clr_so;
  logic [63:0] op_a, op_b, imm, sum;
  logic        ca, ca32, ov, so, cr_vld;
  logic [3:0]  cr_field;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic m_ca, m_ca32, m_ov, m_so;

  always #5 clk = ~clk;

  addx_flags u_dut (
    .clk(clk), .rst(rst), .valid(valid), .op_a(op_a), .op_b(op_b), .imm(imm),
    .imm_en(imm_en), .inv_a(inv_a), .carry_en(carry_en), .ov_en(ov_en),
    .rec_en(rec_en), .clr_so(clr_so), .sum(sum), .ca(ca), .ca32(ca32),
    .ov(ov), .so(so), .cr_field(cr_field), .cr_vld(cr_vld)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [63:0] a, logic [63:0] b, logic [63:0] im,
                        logic ie, logic inv, logic ce, logic oe, logic re, logic clr);
    logic [63:0] ae, s;
    logic        c_n, c32_n, o_n, so_n;
    @(negedge clk);
    valid = 1; op_a = a; op_b = b; imm = im; imm_en = ie; inv_a = inv;
    carry_en = ce; ov_en = oe; rec_en = re; clr_so = clr;
    ae    = inv ? ~a : a;
    s     = ae + b + (ie ? im : 64'd0);
    c_n   = (s < ae) || (s < b) || (ie && (s < im));
    c32_n = (s[31:0] < ae[31:0]) || (s[31:0] < b[31:0]) || (ie && (s[31:0] < im[31:0]));
    o_n   = (ae[63] == b[63]) && (s[63] != ae[63]);
    so_n  = clr ? 1'b0 : (oe ? (m_so | o_n) : m_so);
    #2;
    check("R1 sum", sum, s);
    check("R8 cr_vld", 64'(cr_vld), 64'(re));
    if (re) check("R8 cr_field", 64'(cr_field),
                  64'({s[63], !s[63] && (|s), s == 64'd0, so_n}));
    if (ce) begin m_ca = c_n; m_ca32 = c32_n; end
    if (oe) m_ov = o_n;
    m_so = so_n;
    @(negedge clk);
    valid = 0; clr_so = 0; carry_en = 0; ov_en = 0; rec_en = 0;
    check("R2 ca", 64'(ca), 64'(m_ca));
    check("R3 ca32", 64'(ca32), 64'(m_ca32));
    check("R4 ov", 64'(ov), 64'(m_ov));
    check("R6 so", 64'(so), 64'(m_so));
  endtask

  task automatic t_reset();
    rst = 1; valid = 0; op_a = 0; op_b = 0; imm = 0; imm_en = 0; inv_a = 0;
    carry_en = 0; ov_en = 0; rec_en = 0; clr_so = 0;
    m_ca = 0; m_ca32 = 0; m_ov = 0; m_so = 0;
    repeat (3) @(negedge clk);
    check("R9 reset flags", 64'({ca, ca32, ov, so}), 64'd0);
    rst = 0;
  endtask

  task automatic t_basic();
    run_op(64'd5, 64'd7, 64'd0, 0, 0, 1, 1, 1, 0);
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 0, 0, 1, 1, 1, 0); // R2 wrap to zero
    check("R2 full carry", 64'(ca), 64'd1);
  endtask

  task automatic t_carry31();
    run_op(64'h0000_0000_FFFF_FFFF, 64'd1, 64'd0, 0, 0, 1, 1, 1, 0);
    check("R3 low carry only", 64'({ca, ca32}), 64'b01);
  endtask

  task automatic t_ovf_pos();
    run_op(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 0, 0, 1, 1, 1, 0);
    check("R4 max positive overflow", 64'({ov, so}), 64'b11);
  endtask

  task automatic t_ovf_neg();
    run_op(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0, 0, 0, 1, 1, 1, 0);
    check("R4 min negative overflow", 64'({ca, ov}), 64'b11);
  endtask

  task automatic t_so_sticky();
    run_op(64'd1, 64'd2, 64'd0, 0, 0, 1, 1, 1, 0);
    check("R6 so stays set", 64'({ov, so}), 64'b01);
  endtask

  task automatic t_clear_so();
    run_op(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 64'd0, 0, 0, 0, 1, 1, 1);
    check("R7 clear beats overflow", 64'({ov, so}), 64'b10);
  endtask

  task automatic t_hold();
    logic p_ca, p_ov;
    p_ca = ca; p_ov = ov;
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 0, 0, 0, 0, 1, 0);
    check("R5 ca held", 64'(ca), 64'(p_ca));
    check("R5 ov held", 64'(ov), 64'(p_ov));
  endtask

  task automatic t_imm_inv();
    run_op(64'd0, 64'd0, 64'd1, 1, 1, 1, 1, 1, 0);
    check("R1 inverted a plus imm", sum, 64'd0);
    run_op(64'd10, 64'd20, 64'hFFFF_FFFF_FFFF_FFF0, 1, 0, 1, 1, 0, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_carry31();
    t_ovf_pos();
    t_ovf_neg();
    t_so_sticky();
    t_hold();
    t_clear_so();
    t_imm_inv();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule